// File: doc/BRIEF.md
# Dual-Mode Halfword Multiply-Accumulate Unit

This block is the multiply-accumulate datapath of an integer execute stage. Each operation takes two 32-bit source words and picks one 16-bit halfword from each. It reads them as signed or unsigned values and multiplies them. The product is then added to a 32-bit accumulator word, subtracted from it, or passed through unchanged. The result is a 32-bit word for a general-purpose register, together with a flag that reports when the exact value does not fit.

Each operation chooses between two arithmetic modes. In wraparound mode the result is the low 32 bits of the exact value. In saturating mode an out-of-range result is clamped to the nearest limit of the signed or unsigned 32-bit range. The unit is pipelined with a fixed latency of two cycles and accepts a new operation on every clock. Instruction decode, register-file access and condition-flag updates belong to the surrounding stage.

Top module: `hw_mac`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `result` and `ovf` are all cleared to 0.
- R2: `sel_a_hi`=1 takes bits 31:16 of `src_a` as the first operand, and `sel_a_hi`=0 takes bits 15:0. `sel_b_hi` chooses from `src_b` in the same way.
- R3: With `is_signed`=1, both halfwords and `acc_in` are read as two's complement. With `is_signed`=0 they are read as unsigned.
- R4: With `acc_en`=0, `result` is the 32-bit product and `ovf` is 0. `acc_in`, `acc_sub` and `sat_en` have no effect.
- R5: With `acc_en`=1, the exact value is `acc_in` plus the product when `acc_sub`=0, and `acc_in` minus the product when `acc_sub`=1.
- R6: With `sat_en`=0, `result` is the exact value modulo 2^32.
- R7: With `sat_en`=1 and `is_signed`=1, a result above 2^31-1 becomes 0x7FFFFFFF and a result below -2^31 becomes 0x80000000.
- R8: With `sat_en`=1 and `is_signed`=0, a result above 2^32-1 becomes 0xFFFFFFFF and a result below 0 becomes 0x00000000.
- R9: `ovf` is 1 exactly when the exact value lies outside the 32-bit range for the chosen signedness. This holds in both arithmetic modes. A value that sits on a range limit does not set `ovf`.
- R10: An operation presented with `in_valid`=1 at clock edge k appears on `result`/`ovf` with `out_valid`=1 after edge k+2. A new operation may be presented on every edge.
- R11: After an edge at which no operation completes, `out_valid` is 0 and `result` and `ovf` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| src_a | input | 32 | Source word holding the first operand halfword |
| src_b | input | 32 | Source word holding the second operand halfword |
| acc_in | input | 32 | Accumulator word |
| sel_a_hi | input | 1 | Take the upper halfword of `src_a` |
| sel_b_hi | input | 1 | Take the upper halfword of `src_b` |
| is_signed | input | 1 | Two's complement interpretation of operands and accumulator |
| acc_en | input | 1 | Combine the product with `acc_in` (0: product only) |
| acc_sub | input | 1 | Subtract the product from `acc_in` instead of adding it |
| sat_en | input | 1 | Clamp out-of-range results instead of wrapping |
| out_valid | output | 1 | `result` and `ovf` carry a newly completed operation |
| result | output | 32 | 32-bit result |
| ovf | output | 1 | Exact value was outside the 32-bit range |

## Verification
Range detection and clamping act in the same cycle on the same value. When an out-of-range result is formed, the flag has to rise together with the clamped or wrapped word. The bench provokes this with accumulators placed at and one step past each range limit, in both signednesses and both directions, and with the largest operand products. A behavioural reference model judges each case and compares flag and word together on every clock. Operations with different modes are also issued back to back, so that one retires while the next is being multiplied. This shows that mode bits stay with their own operation through the pipeline.

// File: rtl/hw_mac_pkg.sv
package hw_mac_pkg;
  // Per-operation control that travels with the data through the pipeline
  typedef struct packed {
    logic is_signed;
    logic acc_en;
    logic acc_sub;
    logic sat_en;
  } mac_ctrl_t;
endpackage

// File: rtl/hw_mac_operand.sv
module hw_mac_operand #(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16
) (
  input  logic [DATA_W-1:0]        src,
  input  logic                     sel_hi,
  input  logic                     is_signed,
  output logic signed [HALF_W:0]   opnd
);
  logic [HALF_W-1:0] half;

  always_comb begin
    half = sel_hi ? src[DATA_W-1 -: HALF_W] : src[HALF_W-1:0];
    opnd = {is_signed & half[HALF_W-1], half};
  end
endmodule

// File: rtl/hw_mac_mul_stage.sv
module hw_mac_mul_stage
  import hw_mac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16,
  parameter int SUM_W  = 35
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [HALF_W:0]   opa,
  input  logic signed [HALF_W:0]   opb,
  input  logic [DATA_W-1:0]        acc_in,
  input  mac_ctrl_t                ctrl,
  output logic                     v1,
  output logic signed [SUM_W-1:0]  prod_q,
  output logic signed [SUM_W-1:0]  acc_q,
  output mac_ctrl_t                ctrl_q
);
  localparam int PROD_W = 2 * HALF_W + 2;

  logic signed [PROD_W-1:0] prod_full;
  logic signed [SUM_W-1:0]  prod_ext;
  logic signed [SUM_W-1:0]  acc_ext;

  always_comb begin
    prod_full = opa * opb;
    prod_ext  = {{(SUM_W-PROD_W){prod_full[PROD_W-1]}}, prod_full};
    if (!ctrl.acc_en)
      acc_ext = '0;
    else if (ctrl.is_signed)
      acc_ext = {{(SUM_W-DATA_W){acc_in[DATA_W-1]}}, acc_in};
    else
      acc_ext = {{(SUM_W-DATA_W){1'b0}}, acc_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1     <= 1'b0;
      prod_q <= '0;
      acc_q  <= '0;
      ctrl_q <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        prod_q <= prod_ext;
        acc_q  <= acc_ext;
        ctrl_q <= ctrl;
      end
    end
  end
endmodule

// File: rtl/hw_mac_result_stage.sv
module hw_mac_result_stage
  import hw_mac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SUM_W  = 35
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     v1,
  input  logic signed [SUM_W-1:0]  prod_q,
  input  logic signed [SUM_W-1:0]  acc_q,
  input  mac_ctrl_t                ctrl_q,
  output logic                     out_valid,
  output logic [DATA_W-1:0]        result,
  output logic                     ovf
);
  localparam logic signed [SUM_W-1:0] S_MAX = {{(SUM_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] S_MIN = {{(SUM_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
  localparam logic signed [SUM_W-1:0] U_MAX = {{(SUM_W-DATA_W){1'b0}}, {DATA_W{1'b1}}};
  localparam logic signed [SUM_W-1:0] U_MIN = '0;
  localparam logic [DATA_W-1:0] W_S_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] W_S_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [SUM_W-1:0] sum, lim_hi, lim_lo;
  logic                    above, below;
  logic [DATA_W-1:0]       res_nxt;

  always_comb begin
    sum    = (ctrl_q.acc_en && ctrl_q.acc_sub) ? (acc_q - prod_q) : (acc_q + prod_q);
    lim_hi = ctrl_q.is_signed ? S_MAX : U_MAX;
    lim_lo = ctrl_q.is_signed ? S_MIN : U_MIN;
    above  = sum > lim_hi;
    below  = sum < lim_lo;
    if (ctrl_q.sat_en && above)
      res_nxt = ctrl_q.is_signed ? W_S_MAX : {DATA_W{1'b1}};
    else if (ctrl_q.sat_en && below)
      res_nxt = ctrl_q.is_signed ? W_S_MIN : '0;
    else
      res_nxt = sum[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf       <= 1'b0;
    end else begin
      out_valid <= v1;
      if (v1) begin
        result <= res_nxt;
        ovf    <= above | below;
      end
    end
  end

  // R7
  signed_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (v1 && ctrl_q.sat_en && ctrl_q.is_signed) |=> (!ovf || result == W_S_MAX || result == W_S_MIN));

  // R8
  unsigned_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (v1 && ctrl_q.sat_en && !ctrl_q.is_signed) |=> (!ovf || result == '1 || result == '0));

  // R4
  plain_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (v1 && !ctrl_q.acc_en) |=> !ovf);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !v1 |=> (!out_valid && $stable(result) && $stable(ovf)));
endmodule

// File: rtl/hw_mac.sv
module hw_mac
  import hw_mac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] acc_in,
  input  logic              sel_a_hi,
  input  logic              sel_b_hi,
  input  logic              is_signed,
  input  logic              acc_en,
  input  logic              acc_sub,
  input  logic              sat_en,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              ovf
);
  localparam int HALF_W = DATA_W / 2;
  localparam int SUM_W  = DATA_W + 3;

  logic signed [HALF_W:0]  opnd [2];
  logic [DATA_W-1:0]       srcs [2];
  logic                    sels [2];
  mac_ctrl_t               ctrl, ctrl_q;
  logic                    v1;
  logic signed [SUM_W-1:0] prod_q, acc_q;

  always_comb begin
    srcs[0] = src_a;
    srcs[1] = src_b;
    sels[0] = sel_a_hi;
    sels[1] = sel_b_hi;
    ctrl.is_signed = is_signed;
    ctrl.acc_en    = acc_en;
    ctrl.acc_sub   = acc_sub;
    ctrl.sat_en    = sat_en;
  end

  for (genvar gi = 0; gi < 2; gi++) begin : g_opnd
    hw_mac_operand #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_opnd (
      .src       (srcs[gi]),
      .sel_hi    (sels[gi]),
      .is_signed (is_signed),
      .opnd      (opnd[gi])
    );
  end

  hw_mac_mul_stage #(.DATA_W(DATA_W), .HALF_W(HALF_W), .SUM_W(SUM_W)) u_mul (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .opa      (opnd[0]),
    .opb      (opnd[1]),
    .acc_in   (acc_in),
    .ctrl     (ctrl),
    .v1       (v1),
    .prod_q   (prod_q),
    .acc_q    (acc_q),
    .ctrl_q   (ctrl_q)
  );

  hw_mac_result_stage #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_res (
    .clk       (clk),
    .rst       (rst),
    .v1        (v1),
    .prod_q    (prod_q),
    .acc_q     (acc_q),
    .ctrl_q    (ctrl_q),
    .out_valid (out_valid),
    .result    (result),
    .ovf       (ovf)
  );

  // R10
  latency_valid_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  // R10
  latency_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);
endmodule

// File: tb/hw_mac_tb.sv
module hw_mac_tb;
  logic        clk = 1'b0;
  logic        rst, in_valid, sel_a_hi, sel_b_hi, is_signed, acc_en, acc_sub, sat_en;
  logic [31:0] src_a, src_b, acc_in;
  logic        out_valid, ovf;
  logic [31:0] result;

  always #5 clk = ~clk;

  hw_mac #(.DATA_W(32)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .acc_in(acc_in), .sel_a_hi(sel_a_hi), .sel_b_hi(sel_b_hi), .is_signed(is_signed),
    .acc_en(acc_en), .acc_sub(acc_sub), .sat_en(sat_en),
    .out_valid(out_valid), .result(result), .ovf(ovf)
  );

  typedef struct {
    logic        v;
    logic [31:0] r;
    logic        o;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          checks = 0;
  int          errors = 0;
  logic [31:0] hold_r = '0;
  logic        hold_o = 1'b0;

  task automatic compare();
    exp_t e;
    if (q.size() >= 2) begin
      e = q.pop_front();
      if (e.v) begin
        hold_r = e.r;
        hold_o = e.o;
      end
      checks++;
      if (out_valid !== e.v || result !== hold_r || ovf !== hold_o) begin
        errors++;
        $display("FAIL %s: got valid=%0b result=%h ovf=%0b, expected valid=%0b result=%h ovf=%0b",
                 e.tag, out_valid, result, ovf, e.v, hold_r, hold_o);
      end
    end
  endtask

  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] acc, input logic ahi, input logic bhi,
                      input logic sg, input logic en, input logic sub, input logic sat,
                      input string tag);
    exp_t    e;
    longint  x, y, ac, ex, lo, hi;
    logic    of;
    @(negedge clk);
    compare();
    in_valid = v; src_a = a; src_b = b; acc_in = acc;
    sel_a_hi = ahi; sel_b_hi = bhi; is_signed = sg; acc_en = en; acc_sub = sub; sat_en = sat;
    x  = sg ? longint'($signed(ahi ? a[31:16] : a[15:0])) : longint'(ahi ? a[31:16] : a[15:0]);
    y  = sg ? longint'($signed(bhi ? b[31:16] : b[15:0])) : longint'(bhi ? b[31:16] : b[15:0]);
    ac = sg ? longint'($signed(acc)) : longint'(acc);
    if (!en)      ex = x * y;
    else if (sub) ex = ac - x * y;
    else          ex = ac + x * y;
    lo = sg ? -longint'(64'h8000_0000) : 0;
    hi = sg ? longint'(64'h7FFF_FFFF) : longint'(64'hFFFF_FFFF);
    of = (ex > hi) || (ex < lo);
    e.v = v;
    e.o = of;
    if (sat && ex > hi)      e.r = sg ? 32'h7FFF_FFFF : 32'hFFFF_FFFF;
    else if (sat && ex < lo) e.r = sg ? 32'h8000_0000 : 32'h0000_0000;
    else                     e.r = ex[31:0];
    if (tag != "")     e.tag = tag;
    else if (!v)       e.tag = "R11";
    else if (!en)      e.tag = "R4";
    else if (sat && of) e.tag = sg ? "R7" : "R8";
    else if (of)       e.tag = "R9";
    else if (sub)      e.tag = "R5";
    else               e.tag = "R6";
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, '0, '0, 0, 0, 0, 0, 0, 0, "R11");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10: watchdog expired, got no end of run, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; src_a = '0; src_b = '0; acc_in = '0;
    sel_a_hi = 0; sel_b_hi = 0; is_signed = 0; acc_en = 0; acc_sub = 0; sat_en = 0;
    repeat (3) @(negedge clk);
    checks++;  // R1 reset state
    if (out_valid !== 1'b0 || result !== '0 || ovf !== 1'b0) begin
      errors++;
      $display("FAIL R1: got valid=%0b result=%h ovf=%0b, expected 0 00000000 0", out_valid, result, ovf);
    end
    rst = 1'b0;
    begin
      exp_t e0;
      e0.v = 1'b0; e0.r = '0; e0.o = 1'b0; e0.tag = "R1";
      q.push_back(e0);
      q.push_back(e0);
    end

    // R2 halfword selection, all four combinations, back to back (R10)
    step(1, 32'h0003_0005, 32'h0007_000B, '0, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 32'h0003_0005, 32'h0007_000B, '0, 1, 0, 0, 0, 0, 0, "R2");
    step(1, 32'h0003_0005, 32'h0007_000B, '0, 0, 1, 0, 0, 0, 0, "R2");
    step(1, 32'h0003_0005, 32'h0007_000B, '0, 1, 1, 0, 0, 0, 0, "R10");
    // R3 signedness of operands and accumulator
    step(1, 32'h0000_FFFF, 32'h0000_0002, '0, 0, 0, 1, 0, 0, 0, "R3");
    step(1, 32'h0000_FFFF, 32'h0000_0002, '0, 0, 0, 0, 0, 0, 0, "R3");
    step(1, 32'h8000_0000, 32'h8000_0000, '0, 1, 1, 1, 0, 0, 0, "R3");
    step(1, 32'h0000_0002, 32'h0000_0003, 32'hFFFF_FFF0, 0, 0, 1, 1, 0, 0, "R3");
    idle(2);
    // R4 plain multiply ignores accumulator, subtract and saturate
    step(1, 32'hFFFF_0000, 32'hFFFF_0000, 32'hDEAD_BEEF, 1, 1, 0, 0, 1, 1, "R4");
    step(1, 32'h0000_0004, 32'h0000_0005, 32'hFFFF_FFFF, 0, 0, 1, 0, 1, 1, "R4");
    // R5 add and subtract
    step(1, 32'd10, 32'd20, 32'd1000, 0, 0, 0, 1, 0, 0, "R5");
    step(1, 32'd10, 32'd20, 32'd1000, 0, 0, 0, 1, 1, 0, "R5");
    // R6 wraparound
    step(1, 32'd1, 32'd1, 32'h7FFF_FFFF, 0, 0, 1, 1, 0, 0, "R6");
    step(1, 32'd1, 32'd1, 32'd0, 0, 0, 0, 1, 1, 0, "R6");
    // R7 signed clamps in both directions
    step(1, 32'd1, 32'd1, 32'h7FFF_FFFF, 0, 0, 1, 1, 0, 1, "R7");
    step(1, 32'd1, 32'd1, 32'h8000_0000, 0, 0, 1, 1, 1, 1, "R7");
    step(1, 32'h8000, 32'h8000, 32'h7000_0000, 0, 0, 1, 1, 0, 1, "R7");
    // R8 unsigned clamps in both directions
    step(1, 32'd1, 32'd1, 32'hFFFF_FFFF, 0, 0, 0, 1, 0, 1, "R8");
    step(1, 32'd1, 32'd1, 32'd0, 0, 0, 0, 1, 1, 1, "R8");
    step(1, 32'hFFFF, 32'hFFFF, 32'hFFFF_FFFF, 0, 0, 0, 1, 1, 1, "R8");
    // R9 limits reached exactly: no overflow; one past: overflow
    step(1, 32'd1, 32'd1, 32'h7FFF_FFFE, 0, 0, 1, 1, 0, 1, "R9");
    step(1, 32'd1, 32'd1, 32'h8000_0001, 0, 0, 1, 1, 1, 0, "R9");
    step(1, 32'd1, 32'd1, 32'hFFFF_FFFE, 0, 0, 0, 1, 0, 0, "R9");
    step(1, 32'd1, 32'd1, 32'd1, 0, 0, 0, 1, 1, 0, "R9");
    step(1, 32'd2, 32'd1, 32'd1, 0, 0, 0, 1, 1, 0, "R9");
    // R11 gaps between operations hold the last result
    idle(3);
    step(1, 32'd3, 32'd3, 32'd0, 0, 0, 0, 0, 0, 0, "R10");
    idle(1);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ra, rb, rc;
      logic [7:0]  bits;
      ra = $urandom; rb = $urandom; rc = $urandom; bits = 8'($urandom);
      if (bits[7:6] == 2'b00) rc = {rc[31] ? 4'hF : 4'h7, 28'hFFF_FFF0} ^ {28'h0, rc[3:0]};
      step(bits[0] | bits[1], ra, rb, rc, bits[2], bits[3], bits[4], bits[5], bits[6], bits[7], "");
    end
    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule